// File: doc/BRIEF.md
# Atomic Bit Set/Clear Register Bank

This block holds a bank of 32-bit control registers behind a simple request/response bus that several masters share. A master may read or write any register as a whole word. Each register can also be reached through two alias windows: one forces a single bit to 1, the other forces a single bit to 0. The bit to change is named by a small index in the write data, not by a mask.

An alias update touches exactly one bit and needs no read first. Two masters that each change a different bit of the same register therefore cannot undo one another's change. Changing several bits takes one alias write per bit, and such writes may be issued on consecutive cycles.

An optional gate, chosen by a parameter, lets only transactions marked secure change register contents. Reads stay open to every master. Address bits [15:14] pick the access window, bits [13:2] pick the register, and bits [1:0] are not decoded.

Top module: `atomic_bitreg_bank`

## Requirements
- R1: After reset, every implemented register reads back the parameter RESET_VAL (default 0x0000_0000), and rsp_valid is 0.
- R2: A write with req_addr[15:14]=00 (plain window) replaces the whole addressed register. Every accepted request gives rsp_valid=1 on the following cycle, and a read returns its data on that same cycle.
- R3: A write with req_addr[15:14]=11 (set window) forces bit req_wdata[4:0] of the addressed register to 1 and leaves its other 31 bits unchanged.
- R4: A write with req_addr[15:14]=10 (clear window) forces bit req_wdata[4:0] of the addressed register to 0 and leaves its other 31 bits unchanged.
- R5: In a set or clear write, req_wdata[31:5] has no effect.
- R6: Alias writes accepted on consecutive cycles each take effect. This holds when they target the same register.
- R7: A write with req_addr[15:14]=01 (reserved window) changes no register. A read from that window returns 0.
- R8: When req_addr[13:2] is at or above NUM_REGS, the response has rsp_err=1 and rsp_rdata=0, and a write changes no register. Accesses to implemented registers respond with rsp_err=0.
- R9: With SECURE_GATE=1 (the default), a plain, set or clear write made with req_secure=0 changes nothing. Reads with req_secure=0 still return register contents.
- R10: A read through the set or clear window returns the current value of the addressed register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is presented and accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address: [15:14] window, [13:2] register select |
| req_wdata | input | 32 | Write data; in the alias windows, [4:0] is the bit index |
| req_secure | input | 1 | Transaction carries the secure attribute |
| rsp_valid | output | 1 | Response for the request accepted on the previous cycle |
| rsp_rdata | output | 32 | Read data; 0 for writes, reserved window and unimplemented registers |
| rsp_err | output | 1 | The previous request addressed an unimplemented register |

## Verification
A register bit that is set, cleared or kept wrongly shows up only when that register is read. The bench reads the register right after each group of updates, so the fault appears at rsp_rdata two cycles after the bad write. A decode fault, such as a wrong window, a wrong register or a gate that lets a write through, corrupts a register other than the one addressed or one that should be untouched. The random phase reads every register against a bench model, which catches this. A fault in the response path shows on rsp_valid or rsp_err on the very next cycle.

// File: rtl/abr_pkg.sv
package abr_pkg;
   typedef enum logic [1:0] {
      WIN_PLAIN = 2'b00,
      WIN_RSVD  = 2'b01,
      WIN_CLR   = 2'b10,
      WIN_SET   = 2'b11
   } win_e;
endpackage

// File: rtl/abr_decode.sv
module abr_decode #(
   parameter int NUM_REGS    = 16,
   parameter int ADDR_W      = 16,
   parameter bit SECURE_GATE = 1'b1,
   localparam int SEL_W      = ADDR_W - 4
) (
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic                req_secure,
   output logic [NUM_REGS-1:0] plain_we,
   output logic [NUM_REGS-1:0] set_we,
   output logic [NUM_REGS-1:0] clr_we,
   output logic [SEL_W-1:0]    sel_idx,
   output logic                hit,
   output logic                rd_en
);
   import abr_pkg::*;

   win_e win;
   logic wr_ok;

   assign win     = win_e'(req_addr[ADDR_W-1 -: 2]);
   assign sel_idx = req_addr[ADDR_W-3:2];
   assign hit     = (32'(sel_idx) < NUM_REGS);

   // Gate variant chosen at elaboration
   if (SECURE_GATE) begin : g_gate
      assign wr_ok = req_secure;
   end else begin : g_open
      assign wr_ok = req_secure | 1'b1;
   end

   logic wr_go;
   assign wr_go = req_valid & req_write & hit & wr_ok;
   assign rd_en = req_valid & ~req_write & hit & (win != WIN_RSVD);

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
      logic this_reg;
      assign this_reg    = wr_go & (32'(sel_idx) == i);
      assign plain_we[i] = this_reg & (win == WIN_PLAIN);
      assign set_we[i]   = this_reg & (win == WIN_SET);
      assign clr_we[i]   = this_reg & (win == WIN_CLR);
   end
endmodule

// File: rtl/abr_reg.sv
module abr_reg #(
   parameter int          DATA_W   = 32,
   parameter logic [DATA_W-1:0] RESET_VAL = '0,
   localparam int         IDX_W    = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              plain_we,
   input  logic              set_we,
   input  logic              clr_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   logic [IDX_W-1:0]  bit_sel;
   logic [DATA_W-1:0] onehot;
   logic [DATA_W-1:0] nxt;

   assign bit_sel = wdata[IDX_W-1:0];
   assign onehot  = {{(DATA_W-1){1'b0}}, 1'b1} << bit_sel;

   always_comb begin
      nxt = q;
      if (plain_we)    nxt = wdata;
      else if (set_we) nxt = q | onehot;
      else if (clr_we) nxt = q & ~onehot;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RESET_VAL;
      else        q <= nxt;
   end
endmodule

// File: rtl/abr_resp.sv
module abr_resp #(
   parameter int NUM_REGS = 16,
   parameter int DATA_W   = 32,
   parameter int SEL_W    = 12
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_valid,
   input  logic                         rd_en,
   input  logic                         hit,
   input  logic [SEL_W-1:0]             sel_idx,
   input  logic [NUM_REGS*DATA_W-1:0]   reg_flat,
   output logic                         rsp_valid,
   output logic [DATA_W-1:0]            rsp_rdata,
   output logic                         rsp_err
);
   logic [DATA_W-1:0] mux;

   always_comb begin
      mux = '0;
      for (int i = 0; i < NUM_REGS; i++)
         if (32'(sel_idx) == i) mux = reg_flat[i*DATA_W +: DATA_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
         rsp_err   <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         rsp_rdata <= rd_en ? mux : '0;
         rsp_err   <= req_valid & ~hit;
      end
   end
endmodule

// File: rtl/atomic_bitreg_bank.sv
module atomic_bitreg_bank #(
   parameter int          NUM_REGS    = 16,
   parameter int          DATA_W      = 32,
   parameter int          ADDR_W      = 16,
   parameter logic [31:0] RESET_VAL   = 32'h0000_0000,
   parameter bit          SECURE_GATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [15:0]       req_addr,
   input  logic [31:0]       req_wdata,
   input  logic              req_secure,
   output logic              rsp_valid,
   output logic [31:0]       rsp_rdata,
   output logic              rsp_err
);
   localparam int SEL_W = ADDR_W - 4;

   if (DATA_W != 32) begin : g_bad_width
      $error("DATA_W must be 32");
   end
   if (ADDR_W != 16) begin : g_bad_addr
      $error("ADDR_W must be 16");
   end
   if (NUM_REGS < 1 || NUM_REGS > (1 << SEL_W)) begin : g_bad_depth
      $error("NUM_REGS out of range");
   end

   logic [NUM_REGS-1:0]        plain_we, set_we, clr_we;
   logic [SEL_W-1:0]           sel_idx;
   logic                       hit, rd_en;
   logic [NUM_REGS*DATA_W-1:0] reg_flat;

   abr_decode #(
      .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .SECURE_GATE(SECURE_GATE)
   ) u_dec (
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_secure(req_secure),
      .plain_we  (plain_we),
      .set_we    (set_we),
      .clr_we    (clr_we),
      .sel_idx   (sel_idx),
      .hit       (hit),
      .rd_en     (rd_en)
   );

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      abr_reg #(.DATA_W(DATA_W), .RESET_VAL(RESET_VAL[DATA_W-1:0])) u_reg (
         .clk     (clk),
         .rst_n   (rst_n),
         .plain_we(plain_we[i]),
         .set_we  (set_we[i]),
         .clr_we  (clr_we[i]),
         .wdata   (req_wdata),
         .q       (reg_flat[i*DATA_W +: DATA_W])
      );
   end

   abr_resp #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_rsp (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .rd_en    (rd_en),
      .hit      (hit),
      .sel_idx  (sel_idx),
      .reg_flat (reg_flat),
      .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata),
      .rsp_err  (rsp_err)
   );
endmodule

// File: rtl/abr_chk.sv
module abr_chk #(
   parameter int NUM_REGS    = 16,
   parameter bit SECURE_GATE = 1'b1
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     req_valid,
   input logic                     req_write,
   input logic [15:0]              req_addr,
   input logic [31:0]              req_wdata,
   input logic                     req_secure,
   input logic                     rsp_valid,
   input logic [31:0]              rsp_rdata,
   input logic                     rsp_err,
   input logic [NUM_REGS*32-1:0]   state
);
   logic        in_range;
   logic [31:0] tgt;
   assign in_range = ({20'd0, req_addr[13:2]} < NUM_REGS);
   assign tgt      = {20'd0, req_addr[13:2]} * 32 + {27'd0, req_wdata[4:0]};

   // R2
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R8
   err_on_unimpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !in_range |=> rsp_err && rsp_rdata == 32'd0);

   // R7
   rsvd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_write && req_addr[15:14] == 2'b01 |=> rsp_rdata == 32'd0);

   // R7
   rsvd_write_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_write && req_addr[15:14] == 2'b01 |=> $stable(state));

   // R9
   nonsec_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      SECURE_GATE && req_valid && req_write && !req_secure |=> $stable(state));

   // R3
   set_bit_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_write && (req_secure || !SECURE_GATE) && in_range
      && req_addr[15:14] == 2'b11 |=> state[$past(tgt)]);

   // R4
   clr_bit_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_write && (req_secure || !SECURE_GATE) && in_range
      && req_addr[15:14] == 2'b10 |=> !state[$past(tgt)]);
endmodule

bind atomic_bitreg_bank abr_chk #(.NUM_REGS(NUM_REGS), .SECURE_GATE(SECURE_GATE)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_addr(req_addr), .req_wdata(req_wdata), .req_secure(req_secure),
   .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
   .state(reg_flat));

// File: tb/atomic_bitreg_bank_bench.sv
module atomic_bitreg_bank_bench;
   localparam int          NREG = 16;
   localparam logic [31:0] RV   = 32'h0000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0;
   logic [15:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid, rsp_err;
   logic [31:0] rsp_rdata;

   int tests = 0, fails = 0;
   bit done = 1'b0;
   logic [31:0] model [NREG];

   always #5 clk = ~clk;

   atomic_bitreg_bank #(.NUM_REGS(NREG), .RESET_VAL(RV)) u_atomic_bitreg_bank (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_secure(req_secure),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err));

   function automatic logic [15:0] mk(input logic [1:0] w, input int idx);
      return {w, idx[11:0], 2'b00};
   endfunction

   function automatic void model_apply(input logic [15:0] a, input logic [31:0] d, input bit s);
      int idx = int'(a[13:2]);
      if (!s || idx >= NREG) return;
      case (a[15:14])
         2'b00: model[idx] = d;
         2'b11: model[idx][d[4:0]] = 1'b1;
         2'b10: model[idx][d[4:0]] = 1'b0;
         default: ;
      endcase
   endfunction

   function automatic logic [31:0] model_read(input logic [15:0] a);
      int idx = int'(a[13:2]);
      if (idx >= NREG || a[15:14] == 2'b01) return 32'd0;
      return model[idx];
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one request, response sampled at the following negedge
   task automatic xfer(input bit wr, input logic [15:0] a, input logic [31:0] d, input bit s);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_secure = s;
      if (wr) model_apply(a, d, s);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [15:0] a, input bit s);
      xfer(1'b0, a, 32'd0, s);
      check({req, " rdata"}, rsp_rdata, model_read(a));
      check({req, " err"}, {31'd0, rsp_err}, {31'd0, (int'(a[13:2]) >= NREG)});
   endtask

   initial begin
      for (int i = 0; i < NREG; i++) model[i] = RV;
      repeat (3) @(negedge clk);
      // R1 reset state of the response
      check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
      rst_n = 1'b1;
      for (int i = 0; i < NREG; i++) rd_chk("R1", mk(2'b00, i), 1'b1);

      // R2 plain write, one-cycle read
      xfer(1'b1, mk(2'b00, 2), 32'hA5A5_0F0F, 1'b1);
      check("R2 write rsp_valid", {31'd0, rsp_valid}, 32'd1);
      rd_chk("R2", mk(2'b00, 2), 1'b1);
      // R3 set bit 31, R4 clear bit 0
      xfer(1'b1, mk(2'b11, 2), 32'd31, 1'b1);
      rd_chk("R3", mk(2'b00, 2), 1'b1);
      xfer(1'b1, mk(2'b10, 2), 32'd0, 1'b1);
      rd_chk("R4", mk(2'b00, 2), 1'b1);
      // R5 upper data bits ignored: index 4 with junk above
      xfer(1'b1, mk(2'b11, 2), 32'hFFFF_FFE4, 1'b1);
      rd_chk("R5 set", mk(2'b00, 2), 1'b1);
      xfer(1'b1, mk(2'b10, 2), 32'h8000_0028, 1'b1);
      rd_chk("R5 clr", mk(2'b00, 2), 1'b1);
      // R10 reads through alias windows
      rd_chk("R10 set-win", mk(2'b11, 2), 1'b1);
      rd_chk("R10 clr-win", mk(2'b10, 2), 1'b0);

      // R6 back-to-back set and clear of the same register
      @(negedge clk);
      for (int b = 4; b < 10; b++) begin
         req_valid = 1'b1; req_write = 1'b1; req_secure = 1'b1;
         req_addr = mk(2'b11, 5); req_wdata = b;
         model_apply(req_addr, req_wdata, 1'b1);
         @(negedge clk);
      end
      req_addr = mk(2'b10, 5); req_wdata = 32'd6;
      model_apply(req_addr, req_wdata, 1'b1);
      @(negedge clk);
      req_valid = 1'b0;
      rd_chk("R6", mk(2'b00, 5), 1'b1);
      check("R6 value", model[5], 32'h0000_03B0);

      // R7 reserved window
      xfer(1'b1, mk(2'b01, 5), 32'hFFFF_FFFF, 1'b1);
      rd_chk("R7 keep", mk(2'b00, 5), 1'b1);
      rd_chk("R7 rd0", mk(2'b01, 5), 1'b1);

      // R8 unimplemented register
      xfer(1'b1, mk(2'b00, NREG), 32'h1234_5678, 1'b1);
      check("R8 write err", {31'd0, rsp_err}, 32'd1);
      rd_chk("R8", mk(2'b00, NREG), 1'b1);
      rd_chk("R8 high", mk(2'b00, 4095), 1'b1);
      for (int i = 0; i < NREG; i++) rd_chk("R8 bank", mk(2'b00, i), 1'b1);

      // R9 non-secure writes dropped, reads allowed
      xfer(1'b1, mk(2'b00, 2), 32'h0, 1'b0);
      xfer(1'b1, mk(2'b10, 2), 32'd31, 1'b0);
      xfer(1'b1, mk(2'b11, 7), 32'd3, 1'b0);
      rd_chk("R9 plain/clr", mk(2'b00, 2), 1'b0);
      rd_chk("R9 set", mk(2'b00, 7), 1'b0);

      // random mix against the model
      begin
         int unsigned seed = 32'd1234;
         void'($urandom(seed));
      end
      for (int n = 0; n < 400; n++) begin
         logic [1:0]  w  = 2'($urandom_range(0, 3));
         int          ix = $urandom_range(0, NREG + 1);
         bit          wr = ($urandom_range(0, 2) != 0);
         bit          s  = ($urandom_range(0, 3) != 0);
         logic [31:0] d  = $urandom;
         if (wr) xfer(1'b1, mk(w, ix), d, s);
         else    rd_chk("R3/R4/R9 random", mk(w, ix), s);
      end
      for (int i = 0; i < NREG; i++) rd_chk("R2 final", mk(2'b00, i), 1'b0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule